// File: doc/BRIEF.md
# Partitioned Four-Way LRU Victim Selector

This block keeps the replacement state for one set of a four-way set-associative read cache that sits in front of a flash array. For every lookup it names the way a miss would fill, and on hits and fills it updates the recency order. The tag and data arrays, the set index and the flash timing all live outside the block. The block sees only the hit result and the way that hit.

A 3-bit mode input chooses how the four ways are shared. The ways can form one pool for all traffic. They can also be split between instruction fetches and data reads, two ways to each or three ways to one and one way to the other. Each group keeps its own least-recently-used order. Allocation can be disabled separately for each traffic type. Single ways can be locked against replacement. A per-way invalidate mask clears ways, and it overrides any lock.

The victim outputs are combinational from the current inputs and state. All state changes on the clock edge that follows the access. The asynchronous active-low reset is released through a synchronizer inside the block.

Top module: `lru4_part_sel`

## Requirements
- R1: The effective mode sets the partitions. With 3'b000, all four ways form one group for both access types. With 3'b010, instruction fetches (acc_data_i=0) use ways 0–1 and data reads (acc_data_i=1) use ways 2–3. With 3'b011, instruction fetches use ways 0–2 and data reads use way 3 alone. A victim always lies in the group of the current access type.
- R2: Encoding 3'b001 and every encoding with bit 2 set behave as 3'b000. Any such encoding sets mode_err_o at the next edge, and mode_err_o stays 1 until reset.
- R3: victim_vld_o is 0 whenever the allocation enable of the current access type is 0. Instruction fetches use ifetch_alloc_en_i and data reads use data_alloc_en_i.
- R4: A way whose lock_i bit is 1 is never named as victim. When every way of the group is locked, victim_vld_o is 0.
- R5: Among the unlocked ways of the group, an invalid way (valid_o bit 0) is chosen first. When several are invalid, the lowest index wins.
- R6: When every unlocked way of the group is valid, the victim is the least recently used of those ways in the group's order.
- R7: A hit (acc_vld_i=1, acc_hit_i=1) on hit_way_i makes that way the most recently used of its own group. The order of the other group is not changed.
- R8: A miss (acc_vld_i=1, acc_hit_i=0) with victim_vld_o=1 sets the victim's valid bit at the next edge and makes that way most recently used. A miss with victim_vld_o=0 changes nothing.
- R9: A 1 in inval_i clears that way's valid bit at the next edge, even when the way is locked and even when it is being filled in the same cycle. Ways with a 0 in the mask keep their state.
- R10: Reset leaves all ways invalid and mode_err_o at 0. Reset, and any change of effective mode, puts each group into way-index order, with the lowest index least recently used. A change of mode does not alter the valid bits.
- R11: The victim outputs respond in the same cycle to changes on mode_i, acc_data_i, the allocation enables and lock_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Replacement mode (000, 010, 011; other values reserved) |
| ifetch_alloc_en_i | input | 1 | Instruction fetches may allocate |
| data_alloc_en_i | input | 1 | Data reads may allocate |
| acc_vld_i | input | 1 | Access to this set in the current cycle |
| acc_data_i | input | 1 | Access type: 1 data read, 0 instruction fetch |
| acc_hit_i | input | 1 | The access hit |
| hit_way_i | input | 2 | Way that hit |
| lock_i | input | 4 | Per-way replacement lock |
| inval_i | input | 4 | Per-way invalidate mask |
| victim_way_o | output | 2 | Way a miss would fill |
| victim_vld_o | output | 1 | A victim exists and allocation is allowed |
| valid_o | output | 4 | Per-way valid state |
| mode_err_o | output | 1 | Sticky flag for a reserved mode encoding |

## Verification
On every cycle the assertions check that a named victim is unlocked, lies in its access type's group and is not valid while an invalid candidate exists. They also check that a disabled access type never gets a victim, that invalidated ways read as clear afterwards, that a valid bit rises only after a granted miss, and that the error flag is set by a reserved encoding and then holds. The recency order itself can only be seen through sequences. The bench's reference model shows it by tracking group-local ages across hits, fills, lock patterns and mode changes in every mode, and the directed scenarios show that one group's hits leave the other group's order alone.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int AGE_W  = WAY_W;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_FLAT    = 3'b000;
  localparam logic [MODE_W-1:0] MODE_SPLIT22 = 3'b010;
  localparam logic [MODE_W-1:0] MODE_SPLIT31 = 3'b011;

  typedef logic [WAYS-1:0]            way_mask_t;
  typedef logic [WAYS-1:0][AGE_W-1:0] age_vec_t;

  function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
    return (m != MODE_FLAT) && (m != MODE_SPLIT22) && (m != MODE_SPLIT31);
  endfunction

  function automatic logic [MODE_W-1:0] mode_eff(input logic [MODE_W-1:0] m);
    return mode_reserved(m) ? MODE_FLAT : m;
  endfunction

  // number of low-index ways owned by instruction fetches
  function automatic int ifetch_ways(input logic [MODE_W-1:0] em);
    if (em == MODE_SPLIT22) return 2;
    if (em == MODE_SPLIT31) return 3;
    return WAYS;
  endfunction

  function automatic logic in_data_part(input logic [MODE_W-1:0] em, input int w);
    if (em == MODE_FLAT) return 1'b0;
    return (w >= ifetch_ways(em));
  endfunction

  function automatic way_mask_t elig_mask(input logic [MODE_W-1:0] em, input logic is_data);
    way_mask_t m;
    for (int w = 0; w < WAYS; w++)
      m[w] = (em == MODE_FLAT) ? 1'b1 : (in_data_part(em, w) == is_data);
    return m;
  endfunction

  // way-index order: lowest index of a group is oldest
  function automatic logic [AGE_W-1:0] init_age(input logic [MODE_W-1:0] em, input int w);
    int hi;
    if (em == MODE_FLAT) hi = WAYS - 1;
    else hi = (w < ifetch_ways(em)) ? ifetch_ways(em) - 1 : WAYS - 1;
    return AGE_W'(hi - w);
  endfunction
endpackage

// File: rtl/lru4_rst_sync.sv
module lru4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shreg <= '0;
    else         shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign srst_n = shreg[STAGES-1];
endmodule

// File: rtl/lru4_victim_pick.sv
module lru4_victim_pick
  import lru4_pkg::*;
(
  input  way_mask_t        elig,
  input  way_mask_t        lock,
  input  way_mask_t        valid,
  input  age_vec_t         age,
  input  logic             alloc_en,
  output logic [WAY_W-1:0] victim_way,
  output logic             victim_vld
);
  way_mask_t        cand;
  way_mask_t        free;
  logic             free_found;
  logic             old_found;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;
  logic [AGE_W-1:0] old_age;

  assign cand = elig & ~lock;
  assign free = cand & ~valid;

  // lowest-index invalid candidate
  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (free[w] && !free_found) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
  end

  // oldest candidate, ties to lowest index
  always_comb begin
    old_found = 1'b0;
    old_way   = '0;
    old_age   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (cand[w] && (!old_found || age[w] > old_age)) begin
        old_found = 1'b1;
        old_way   = WAY_W'(w);
        old_age   = age[w];
      end
    end
  end

  assign victim_way = free_found ? free_way : old_way;
  assign victim_vld = alloc_en && (|cand);
endmodule

// File: rtl/lru4_age_upd.sv
module lru4_age_upd
  import lru4_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  age_vec_t          age_cur,
  input  logic              touch,
  input  logic [WAY_W-1:0]  touch_way,
  output age_vec_t          age_nxt
);
  logic [AGE_W-1:0] touch_age;
  logic             touch_side;

  assign touch_age  = age_cur[touch_way];
  assign touch_side = in_data_part(mode, int'(touch_way));

  always_comb begin
    age_nxt = age_cur;
    if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_nxt[w] = '0;
        else if ((in_data_part(mode, w) == touch_side) && (age_cur[w] < touch_age))
          age_nxt[w] = age_cur[w] + AGE_W'(1);
      end
    end
  end
endmodule

// File: rtl/lru4_part_sel.sv
module lru4_part_sel
  import lru4_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ifetch_alloc_en_i,
  input  logic              data_alloc_en_i,
  input  logic              acc_vld_i,
  input  logic              acc_data_i,
  input  logic              acc_hit_i,
  input  logic [WAY_W-1:0]  hit_way_i,
  input  logic [WAYS-1:0]   lock_i,
  input  logic [WAYS-1:0]   inval_i,
  output logic [WAY_W-1:0]  victim_way_o,
  output logic              victim_vld_o,
  output logic [WAYS-1:0]   valid_o,
  output logic              mode_err_o
);
  logic              rst_s_n;
  logic [MODE_W-1:0] em;
  logic [MODE_W-1:0] mode_q;
  logic              mode_chg;
  age_vec_t          age_q;
  age_vec_t          age_base;
  age_vec_t          age_rst;
  age_vec_t          age_nxt;
  way_mask_t         valid_q;
  way_mask_t         valid_nxt;
  way_mask_t         elig;
  way_mask_t         fill_mask;
  logic              err_q;
  logic              alloc_en;
  logic              fill;
  logic              touch;
  logic [WAY_W-1:0]  touch_way;
  logic              age_en;
  logic              valid_en;
  logic              err_set;

  lru4_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  assign em       = mode_eff(mode_i);
  assign mode_chg = (em != mode_q);

  // recency seen this cycle: fresh order on a mode change
  for (genvar g = 0; g < WAYS; g++) begin : g_age
    assign age_rst[g]  = init_age(MODE_FLAT, g);
    assign age_base[g] = mode_chg ? init_age(em, g) : age_q[g];
  end

  assign alloc_en = acc_data_i ? data_alloc_en_i : ifetch_alloc_en_i;
  assign elig     = elig_mask(em, acc_data_i);

  lru4_victim_pick u_pick (
    .elig       (elig),
    .lock       (lock_i),
    .valid      (valid_q),
    .age        (age_base),
    .alloc_en   (alloc_en),
    .victim_way (victim_way_o),
    .victim_vld (victim_vld_o)
  );

  assign fill      = acc_vld_i && !acc_hit_i && victim_vld_o;
  assign touch     = acc_vld_i && (acc_hit_i || victim_vld_o);
  assign touch_way = acc_hit_i ? hit_way_i : victim_way_o;

  lru4_age_upd u_age (
    .mode      (em),
    .age_cur   (age_base),
    .touch     (touch),
    .touch_way (touch_way),
    .age_nxt   (age_nxt)
  );

  assign fill_mask = fill ? (way_mask_t'(1) << victim_way_o) : '0;
  assign valid_nxt = (valid_q | fill_mask) & ~inval_i;

  assign age_en   = touch || mode_chg;
  assign valid_en = fill || (|inval_i);
  assign err_set  = mode_reserved(mode_i);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q  <= MODE_FLAT;
      age_q   <= age_rst;
      valid_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (mode_chg) mode_q  <= em;
      if (age_en)   age_q   <= age_nxt;
      if (valid_en) valid_q <= valid_nxt;
      if (err_set)  err_q   <= 1'b1;
    end
  end

  assign valid_o    = valid_q;
  assign mode_err_o = err_q;
endmodule

// File: rtl/lru4_sel_chk.sv
module lru4_sel_chk
  import lru4_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_i,
  input logic              ifetch_alloc_en_i,
  input logic              data_alloc_en_i,
  input logic              acc_vld_i,
  input logic              acc_data_i,
  input logic              acc_hit_i,
  input logic [WAYS-1:0]   lock_i,
  input logic [WAYS-1:0]   inval_i,
  input logic [WAY_W-1:0]  victim_way_o,
  input logic              victim_vld_o,
  input logic [WAYS-1:0]   valid_o,
  input logic              mode_err_o
);
  logic            split22;
  logic            split31;
  logic            in_part;
  logic [WAYS-1:0] grp;
  logic            rsv;

  assign split22 = (mode_i == 3'b010);
  assign split31 = (mode_i == 3'b011);
  assign rsv     = !(mode_i == 3'b000 || split22 || split31);
  assign in_part = split22 ? (acc_data_i ? (victim_way_o >= 2'd2) : (victim_way_o < 2'd2)) :
                   split31 ? (acc_data_i ? (victim_way_o == 2'd3) : (victim_way_o < 2'd3)) :
                   1'b1;
  assign grp     = split22 ? (acc_data_i ? 4'b1100 : 4'b0011) :
                   split31 ? (acc_data_i ? 4'b1000 : 4'b0111) : 4'b1111;

  AST_VICTIM_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld_o |-> in_part); // R1

  AST_RSV_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rsv |=> mode_err_o); // R2

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |=> mode_err_o); // R2

  AST_ALLOC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_data_i ? !data_alloc_en_i : !ifetch_alloc_en_i) |-> !victim_vld_o); // R3

  AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld_o |-> !lock_i[victim_way_o]); // R4

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_vld_o && (|(grp & ~lock_i & ~valid_o))) |-> !valid_o[victim_way_o]); // R5

  AST_RISE_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (|(valid_o & ~$past(valid_o))) |-> $past(acc_vld_i && !acc_hit_i && victim_vld_o)); // R8

  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|inval_i) |=> ((valid_o & $past(inval_i)) == '0)); // R9
endmodule

bind lru4_part_sel lru4_sel_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_s_n),
  .mode_i            (mode_i),
  .ifetch_alloc_en_i (ifetch_alloc_en_i),
  .data_alloc_en_i   (data_alloc_en_i),
  .acc_vld_i         (acc_vld_i),
  .acc_data_i        (acc_data_i),
  .acc_hit_i         (acc_hit_i),
  .lock_i            (lock_i),
  .inval_i           (inval_i),
  .victim_way_o      (victim_way_o),
  .victim_vld_o      (victim_vld_o),
  .valid_o           (valid_o),
  .mode_err_o        (mode_err_o)
);

// File: tb/tb_lru4_part_sel.sv
`timescale 1ns/1ps
module tb_lru4_part_sel;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode_i;
  logic       ifetch_alloc_en_i, data_alloc_en_i;
  logic       acc_vld_i, acc_data_i, acc_hit_i;
  logic [1:0] hit_way_i;
  logic [3:0] lock_i, inval_i;
  logic [1:0] victim_way_o;
  logic       victim_vld_o;
  logic [3:0] valid_o;
  logic       mode_err_o;

  always #2.5 clk = ~clk;

  lru4_part_sel dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .ifetch_alloc_en_i(ifetch_alloc_en_i), .data_alloc_en_i(data_alloc_en_i),
    .acc_vld_i(acc_vld_i), .acc_data_i(acc_data_i), .acc_hit_i(acc_hit_i),
    .hit_way_i(hit_way_i), .lock_i(lock_i), .inval_i(inval_i),
    .victim_way_o(victim_way_o), .victim_vld_o(victim_vld_o),
    .valid_o(valid_o), .mode_err_o(mode_err_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model
  logic [3:0]  m_valid;
  int          m_age [4];
  logic [2:0]  m_mode;
  logic        m_err;
  logic [3:0]  last_inv;
  bit          e_vld;
  int          e_way;
  string       e_tag;
  logic [31:0] seed = 32'h1234_5679;

  function automatic bit m_rsv(input logic [2:0] m);
    return !(m == 3'd0 || m == 3'd2 || m == 3'd3);
  endfunction
  function automatic logic [2:0] m_eff(input logic [2:0] m);
    return m_rsv(m) ? 3'd0 : m;
  endfunction
  // group index: 0 instruction side, 1 data side (flat mode: 0)
  function automatic int m_side(input logic [2:0] em, input int w);
    if (em == 3'd2) return (w >= 2) ? 1 : 0;
    if (em == 3'd3) return (w >= 3) ? 1 : 0;
    return 0;
  endfunction
  function automatic int m_top(input logic [2:0] em, input int w);
    if (em == 3'd2) return (w < 2) ? 1 : 3;
    if (em == 3'd3) return (w < 3) ? 2 : 3;
    return 3;
  endfunction
  function automatic bit m_elig(input logic [2:0] em, input bit d, input int w);
    if (em == 3'd0) return 1'b1;
    return m_side(em, w) == int'(d);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic m_reinit(input logic [2:0] em);
    for (int w = 0; w < 4; w++) m_age[w] = m_top(em, w) - w;
  endtask

  task automatic expect_victim();
    bit en, any, fnd;
    int best;
    en  = acc_data_i ? data_alloc_en_i : ifetch_alloc_en_i;
    any = 0; fnd = 0; e_way = 0; best = -1;
    for (int w = 0; w < 4; w++)
      if (m_elig(m_mode, acc_data_i, w) && !lock_i[w]) begin
        any = 1;
        if (!m_valid[w] && !fnd) begin fnd = 1; e_way = w; end
      end
    if (!fnd)
      for (int w = 0; w < 4; w++)
        if (m_elig(m_mode, acc_data_i, w) && !lock_i[w] && m_age[w] > best) begin
          best = m_age[w]; e_way = w;
        end
    e_vld = en && any;
    if (!en)       e_tag = "R3";
    else if (!any) e_tag = "R4";
    else if (fnd)  e_tag = "R5";
    else           e_tag = "R6";
  endtask

  task automatic drive(input logic [2:0] md, input logic ie, input logic de, input logic isd,
                       input logic av, input logic hit, input logic [1:0] hw,
                       input logic [3:0] lk, input logic [3:0] inv);
    @(negedge clk);
    mode_i = md; ifetch_alloc_en_i = ie; data_alloc_en_i = de; acc_data_i = isd;
    acc_vld_i = av; acc_hit_i = hit; hit_way_i = hw; lock_i = lk; inval_i = inv;
    #1;
    if (m_eff(md) != m_mode) begin m_mode = m_eff(md); m_reinit(m_mode); end
    expect_victim();
    chk(valid_o == m_valid, (last_inv != 0) ? "R9" : "R8", "valid_o", valid_o, m_valid);
    chk(mode_err_o == m_err, "R2", "mode_err_o", mode_err_o, m_err);
    chk(victim_vld_o == e_vld, e_tag, "victim_vld_o", victim_vld_o, e_vld);
    if (e_vld) chk(int'(victim_way_o) == e_way, e_tag, "victim_way_o", victim_way_o, e_way);
  endtask

  task automatic commit();
    int tw, ta;
    bit touch;
    @(posedge clk);
    touch = acc_vld_i && (acc_hit_i || e_vld);
    tw    = acc_hit_i ? int'(hit_way_i) : e_way;
    if (touch) begin
      ta = m_age[tw];
      for (int w = 0; w < 4; w++)
        if (w != tw && m_side(m_mode, w) == m_side(m_mode, tw) && m_age[w] < ta) m_age[w]++;
      m_age[tw] = 0;
    end
    if (acc_vld_i && !acc_hit_i && e_vld) m_valid[e_way] = 1'b1;
    m_valid  = m_valid & ~inval_i;
    m_err    = m_err | m_rsv(mode_i);
    last_inv = inval_i;
  endtask

  task automatic idle(input logic [2:0] md, input logic isd, input logic [3:0] lk);
    drive(md, 1, 1, isd, 0, 0, 2'd0, lk, 4'd0);
  endtask

  task automatic next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] phase_modes [5];
    rst_n = 0; mode_i = 0; ifetch_alloc_en_i = 0; data_alloc_en_i = 0;
    acc_vld_i = 0; acc_data_i = 0; acc_hit_i = 0; hit_way_i = 0; lock_i = 0; inval_i = 0;
    m_valid = 0; m_mode = 0; m_err = 0; last_inv = 0; m_reinit(3'd0);
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R10: reset state
    idle(3'd0, 0, 4'd0);
    chk(valid_o == 4'd0, "R10", "valid after reset", valid_o, 0);
    chk(mode_err_o == 1'b0, "R10", "err after reset", mode_err_o, 0);
    chk(victim_way_o == 2'd0, "R5", "first free way", victim_way_o, 0);
    commit();

    // R8: four fills by instruction misses in flat mode
    for (int i = 0; i < 4; i++) begin
      drive(3'd0, 1, 1, 0, 1, 0, 2'd0, 4'd0, 4'd0);
      chk(int'(victim_way_o) == i, "R8", "fill order", victim_way_o, i);
      commit();
    end
    idle(3'd0, 0, 4'd0);
    chk(valid_o == 4'hF, "R8", "all filled", valid_o, 15);
    chk(victim_way_o == 2'd0, "R6", "oldest way", victim_way_o, 0);
    commit();
    drive(3'd0, 1, 1, 0, 1, 1, 2'd0, 4'd0, 4'd0); commit();
    idle(3'd0, 0, 4'd0);
    chk(victim_way_o == 2'd1, "R6", "oldest after hit", victim_way_o, 1);
    commit();

    // R10: mode change restores way-index order
    idle(3'd2, 0, 4'd0);
    chk(victim_way_o == 2'd0, "R10", "ifetch after mode change", victim_way_o, 0);
    commit();
    idle(3'd2, 1, 4'd0);
    chk(victim_way_o == 2'd2, "R10", "data after mode change", victim_way_o, 2);
    chk(valid_o == 4'hF, "R10", "valid kept over mode change", valid_o, 15);
    commit();

    // R7: hits touch only their own group
    drive(3'd2, 1, 1, 1, 1, 1, 2'd2, 4'd0, 4'd0); commit();
    idle(3'd2, 1, 4'd0);
    chk(victim_way_o == 2'd3, "R7", "data order after data hit", victim_way_o, 3);
    commit();
    idle(3'd2, 0, 4'd0);
    chk(victim_way_o == 2'd0, "R7", "ifetch order untouched", victim_way_o, 0);
    commit();
    drive(3'd2, 1, 1, 0, 1, 1, 2'd0, 4'd0, 4'd0); commit();
    idle(3'd2, 0, 4'd0);
    chk(victim_way_o == 2'd1, "R7", "ifetch order after hit", victim_way_o, 1);
    commit();
    idle(3'd2, 1, 4'd0);
    chk(victim_way_o == 2'd3, "R7", "data order untouched", victim_way_o, 3);
    commit();

    // R11 / R4 / R3
    idle(3'd2, 0, 4'b0010);
    chk(victim_vld_o && victim_way_o == 2'd0, "R11", "lock seen same cycle", victim_way_o, 0);
    commit();
    idle(3'd2, 0, 4'b0011);
    chk(victim_vld_o == 1'b0, "R4", "group all locked", victim_vld_o, 0);
    commit();
    drive(3'd2, 0, 1, 0, 1, 0, 2'd0, 4'd0, 4'd0);
    chk(victim_vld_o == 1'b0, "R3", "ifetch alloc disabled", victim_vld_o, 0);
    commit();

    // R9: invalidate beats locks
    drive(3'd2, 1, 1, 0, 0, 0, 2'd0, 4'hF, 4'b0101); commit();
    idle(3'd2, 0, 4'd0);
    chk(valid_o == 4'b1010, "R9", "locked ways cleared", valid_o, 10);
    commit();

    // R2: reserved encoding
    idle(3'd5, 0, 4'd0); commit();
    idle(3'd0, 0, 4'd0);
    chk(mode_err_o == 1'b1, "R2", "err set", mode_err_o, 1);
    commit();
    idle(3'd0, 0, 4'd0);
    chk(mode_err_o == 1'b1, "R2", "err sticky", mode_err_o, 1);
    commit();

    // R1: three/one split
    idle(3'd3, 1, 4'd0);
    chk(victim_vld_o && victim_way_o == 2'd3, "R1", "data alone in way 3", victim_way_o, 3);
    commit();

    // sweeps over every mode class, model-checked each cycle (R1 R4 R5 R6 R7 R8 R9)
    phase_modes[0] = 3'd0; phase_modes[1] = 3'd2; phase_modes[2] = 3'd3;
    phase_modes[3] = 3'd1; phase_modes[4] = 3'd6;
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < 600; i++) begin
        next_rand();
        drive(phase_modes[p], seed[0] | seed[1], seed[3] | seed[4], seed[6],
              seed[7] | seed[8], seed[9], seed[11:10],
              seed[15:12] & seed[19:16], seed[23:20] & seed[27:24] & {4{seed[28]}});
        commit();
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule